// File: doc/BRIEF.md
# Read-Once Device Secret Register Bank

This block is a small register bank that sits on a 32-bit processor bus. It holds a 256-bit secret that is unique to each device, and it also holds three fixed words: two identification words and a version word. The secret is split into eight 32-bit words. Boot firmware can fetch each word once, for example to derive keys. After that first fetch the word reads as zero until the next power-on reset.

An input called `app_mode` marks cycles that belong to an untrusted application. While it is high the whole bank reads as zero, and a read in that state does not use up any secret word.

The bus is a plain chip-select interface. Reads are registered, so read data appears one cycle after the request. The bank has no writable state. A write does not change the bank, but it raises a one-cycle error pulse.

The word map is as follows:
- Word 0 holds the first identification word.
- Word 1 holds the second identification word.
- Word 2 holds the version word.
- Words 3 to 7 are unused.
- Words 8 to 15 hold the secret.

Top module: `secret_bank`

## Requirements
- R1: While `rst_n` is low, and on the first cycles after it is released, `rdata` and `access_err` are 0.
- R2: In firmware mode (`app_mode`=0), a read of address 0, 1 or 2 returns `ID_WORD0`, `ID_WORD1` or `VERSION_WORD`. The value appears on `rdata` in the cycle after the request, and these words can be read any number of times.
- R3: In firmware mode, the first read of address 8+i (i = 0..7) returns bits [32i+31:32i] of `SECRET`. The secret is little-endian: secret byte 0 is in bits 7:0 of word 0.
- R4: Every later read of a secret word that has already been read returns 0. Reading one secret word does not affect any other secret word.
- R5: When `app_mode`=1 during a read request, every address returns 0. Such a read does not mark any secret word as read, so a later firmware read still returns the secret.
- R6: A write (`cs`=1, `we`=1) to any address changes nothing in the bank and returns 0 on `rdata`. It drives `access_err` high for exactly the next cycle. `access_err` is low after every cycle that is not a write.
- R7: `rdata` is 0 in every cycle that does not follow a read request. Reads of the unused addresses 3 to 7 return 0.
- R8: A word that has been read stays spent through any sequence of mode changes, reads and writes. Only an assertion of `rst_n` makes it readable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert and synchronous release |
| app_mode | input | 1 | 1 = application (unprivileged) mode, sampled with the request |
| cs | input | 1 | Bus request strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data (discarded) |
| rdata | output | 32 | Registered read data, valid one cycle after a read request |
| access_err | output | 1 | One-cycle pulse after any write request |

## Verification
The embedded properties check the following on every cycle:
- the error pulse follows writes and only writes;
- read data is zero after idle cycles, writes and application-mode reads;
- a spent flag never falls outside reset;
- no flag moves on an application-mode cycle;
- at most one flag is set per cycle.

Some behaviour depends on values rather than on single-cycle relations, so only the bench scenarios show it:
- the correct identification, version and secret word appears at each address;
- a word returns zero on its second read while its neighbours are untouched;
- writes and application-mode reads leave the secret intact;
- a power-on reset re-arms every word.

// File: rtl/secret_bank_pkg.sv
package secret_bank_pkg;

  // Region selected by a word address
  typedef enum logic [2:0] {
    RGN_ID0,
    RGN_ID1,
    RGN_VER,
    RGN_SECRET,
    RGN_NONE
  } region_e;

  localparam logic [1:0] ADDR_ID0 = 2'd0;
  localparam logic [1:0] ADDR_ID1 = 2'd1;
  localparam logic [1:0] ADDR_VER = 2'd2;

endpackage

// File: rtl/sb_reset_sync.sv
module sb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sb_decode.sv
module sb_decode
  import secret_bank_pkg::*;
#(
  parameter int SECRET_WORDS = 8,
  localparam int IDX_W  = $clog2(SECRET_WORDS),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  // Upper half of the map holds the secret; lower half the fixed words
  always_comb begin
    idx    = addr[IDX_W-1:0];
    region = RGN_NONE;
    if (addr[ADDR_W-1]) begin
      region = RGN_SECRET;
    end else if (addr[IDX_W-1:2] == '0) begin
      case (addr[1:0])
        ADDR_ID0: region = RGN_ID0;
        ADDR_ID1: region = RGN_ID1;
        ADDR_VER: region = RGN_VER;
        default:  region = RGN_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sb_spent_flags.sv
module sb_spent_flags
  import secret_bank_pkg::*;
#(
  parameter int SECRET_WORDS = 8,
  localparam int IDX_W = $clog2(SECRET_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic                    app_mode,
  input  region_e                 region,
  input  logic [IDX_W-1:0]        idx,
  output logic [SECRET_WORDS-1:0] spent
);

  logic                    mark_en;
  logic [SECRET_WORDS-1:0] spent_q;
  logic [SECRET_WORDS-1:0] spent_d;

  assign mark_en = rd_req && !app_mode && (region == RGN_SECRET);

  generate
    for (genvar g = 0; g < SECRET_WORDS; g++) begin : g_flag
      always_comb begin
        spent_d[g] = spent_q[g];
        if (mark_en && (idx == IDX_W'(g))) spent_d[g] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) spent_q[g] <= 1'b0;
        else        spent_q[g] <= spent_d[g];
      end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spent_q[g] |=> spent_q[g]); // R8
    end
  endgenerate

  assign spent = spent_q;

  AST_APP_NO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    app_mode |=> $stable(spent_q)); // R5

  AST_ONE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(spent_q & ~$past(spent_q)) <= 1); // R4

endmodule

// File: rtl/sb_read_path.sv
module sb_read_path
  import secret_bank_pkg::*;
#(
  parameter int                            DATA_W       = 32,
  parameter int                            SECRET_WORDS = 8,
  parameter logic [DATA_W-1:0]              ID_WORD0     = '0,
  parameter logic [DATA_W-1:0]              ID_WORD1     = '0,
  parameter logic [DATA_W-1:0]              VERSION_WORD = '0,
  parameter logic [SECRET_WORDS*DATA_W-1:0] SECRET       = '0,
  localparam int IDX_W = $clog2(SECRET_WORDS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_req,
  input  logic                    app_mode,
  input  region_e                 region,
  input  logic [IDX_W-1:0]        idx,
  input  logic [SECRET_WORDS-1:0] spent,
  output logic [DATA_W-1:0]       rdata
);

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              rd_ok;

  assign rd_ok = rd_req && !app_mode;

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      case (region)
        RGN_ID0:    rdata_d = ID_WORD0;
        RGN_ID1:    rdata_d = ID_WORD1;
        RGN_VER:    rdata_d = VERSION_WORD;
        RGN_SECRET: if (!spent[idx]) rdata_d = SECRET[idx*DATA_W +: DATA_W];
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_SPENT_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && region == RGN_SECRET && spent[idx]) |=> rdata_q == '0); // R4

endmodule

// File: rtl/secret_bank.sv
module secret_bank
  import secret_bank_pkg::*;
#(
  parameter int                             DATA_W       = 32,
  parameter int                             SECRET_WORDS = 8,
  parameter logic [DATA_W-1:0]              ID_WORD0     = 32'h5345_4352,
  parameter logic [DATA_W-1:0]              ID_WORD1     = 32'h4241_4E4B,
  parameter logic [DATA_W-1:0]              VERSION_WORD = 32'h0001_0002,
  parameter logic [SECRET_WORDS*DATA_W-1:0] SECRET       =
    256'h1F1E1D1C_1B1A1918_17161514_13121110_0F0E0D0C_0B0A0908_07060504_03020100,
  localparam int IDX_W  = $clog2(SECRET_WORDS),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              app_mode,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              access_err
);

  logic                    rst_sync_n;
  logic                    rd_req;
  logic                    wr_req;
  region_e                 region;
  logic [IDX_W-1:0]        idx;
  logic [SECRET_WORDS-1:0] spent;
  logic                    err_q;
  logic                    err_d;

  assign rd_req = cs && !we;
  assign wr_req = cs && we;

  sb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sb_decode #(.SECRET_WORDS(SECRET_WORDS)) u_dec (
    .addr   (addr),
    .region (region),
    .idx    (idx)
  );

  sb_spent_flags #(.SECRET_WORDS(SECRET_WORDS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .app_mode (app_mode),
    .region   (region),
    .idx      (idx),
    .spent    (spent)
  );

  sb_read_path #(
    .DATA_W       (DATA_W),
    .SECRET_WORDS (SECRET_WORDS),
    .ID_WORD0     (ID_WORD0),
    .ID_WORD1     (ID_WORD1),
    .VERSION_WORD (VERSION_WORD),
    .SECRET       (SECRET)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_req   (rd_req),
    .app_mode (app_mode),
    .region   (region),
    .idx      (idx),
    .spent    (spent),
    .rdata    (rdata)
  );

  // Write strobe becomes a one-cycle error pulse; data is discarded
  always_comb begin
    err_d = wr_req;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign access_err = err_q;

  AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && we) |=> access_err); // R6

  AST_ERR_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cs && we) |=> !access_err); // R6

  AST_WRITE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && we && (wdata != '0)) |=> rdata == '0); // R6

  AST_APP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cs && !we && app_mode) |=> rdata == '0); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(cs && !we) |=> rdata == '0); // R7

endmodule

// File: tb/secret_bank_tb.sv
module secret_bank_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam logic [31:0] ID0 = 32'hC0DE_0001;
  localparam logic [31:0] ID1 = 32'hC0DE_0002;
  localparam logic [31:0] VER = 32'h0003_0104;

  function automatic logic [31:0] exp_word(int i);
    return 32'hA55A_0000 ^ (i * 32'h0101_0111) ^ 32'h1357_9BDF;
  endfunction

  function automatic logic [NW*32-1:0] build_secret();
    logic [NW*32-1:0] s;
    for (int i = 0; i < NW; i++) s[i*32 +: 32] = exp_word(i);
    return s;
  endfunction

  localparam logic [NW*32-1:0] SEC = build_secret();

  logic        clk = 1'b0;
  logic        rst_n;
  logic        app_mode;
  logic        cs;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        access_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  secret_bank #(
    .ID_WORD0(ID0), .ID_WORD1(ID1), .VERSION_WORD(VER), .SECRET(SEC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .app_mode(app_mode), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .access_err(access_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0; app_mode = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 err in reset", {31'h0, access_err}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 err after reset", {31'h0, access_err}, 32'h0);
  endtask

  // Read request for one cycle; result sampled at the following negedge
  task automatic rd(input logic [3:0] a, input logic m, output logic [31:0] d, output logic e);
    @(negedge clk);
    cs = 1'b1; we = 1'b0; addr = a; app_mode = m;
    @(negedge clk);
    cs = 1'b0; app_mode = 1'b0;
    d = rdata; e = access_err;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v, output logic [31:0] d, output logic e);
    @(negedge clk);
    cs = 1'b1; we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; wdata = '0;
    d = rdata; e = access_err;
  endtask

  function automatic logic [31:0] fw_fixed(int a);
    case (a)
      0: return ID0;
      1: return ID1;
      2: return VER;
      default: return 32'h0;
    endcase
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic        e;
    do_reset();

    // R5: application mode hides everything
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), 1'b1, d, e);
      check("R5 app read zero", d, 32'h0);
      check("R6 no err on read", {31'h0, e}, 32'h0);
    end

    // R6: writes everywhere are ignored and pulse the error
    for (int a = 0; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_0000 | 32'(a), d, e);
      check("R6 write rdata zero", d, 32'h0);
      check("R6 err pulse", {31'h0, e}, 32'h1);
      @(negedge clk);
      check("R6 err single cycle", {31'h0, access_err}, 32'h0);
    end

    // R2 R3 R7: firmware sweep of whole map
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), 1'b0, d, e);
      if (a >= 8) check("R3 first secret read", d, exp_word(a - 8));
      else if (a < 3) check("R2 fixed word", d, fw_fixed(a));
      else check("R7 unused addr zero", d, 32'h0);
      @(negedge clk);
      check("R7 idle rdata zero", rdata, 32'h0);
    end

    // R4: second reads are zero; fixed words still readable
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), 1'b0, d, e);
      if (a >= 8) check("R4 spent word zero", d, 32'h0);
      else check("R2 reread fixed", d, fw_fixed(a));
    end

    // R8: mode flips and writes do not re-arm
    rd(4'd9, 1'b1, d, e);
    wr(4'd9, 32'h1234_5678, d, e);
    rd(4'd9, 1'b0, d, e);
    check("R8 no rearm by mode/write", d, 32'h0);

    // R8: power-on reset re-arms; R4 independence
    do_reset();
    rd(4'd11, 1'b0, d, e);
    check("R8 rearmed after reset", d, exp_word(3));
    rd(4'd11, 1'b0, d, e);
    check("R4 spent after one read", d, 32'h0);
    rd(4'd13, 1'b1, d, e);
    check("R5 app read of fresh word", d, 32'h0);
    for (int i = 0; i < NW; i++) begin
      rd(4'(8 + i), 1'b0, d, e);
      check("R4 neighbours intact", d, (i == 3) ? 32'h0 : exp_word(i));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule